// File: doc/BRIEF.md
# Power wake-up output controller

This block owns the active-low power-enable pin that switches a host's main supply back on. Two kinds of event can wake the host. One is a single-cycle alarm-match strobe from the calendar. The other is a kickstart button input that has to stay low over several slow-clock samples. Each kind of event sets its own sticky flag. While either flag is set, the pin is pulled low.

Software clears a flag by writing 0 to its bit; writing 1 leaves the flag alone. When both flags are clear, the pin is released. If the host never brings main power up, a power-on timeout of a fixed number of seconds releases the pin. A select input decides the pin's state once main power is gone and nothing is waking the host. With the select at 0 the pin floats. With the select at 1 it keeps driving high. Events are still watched while power is absent.

The pin is a tri-state driver described by two outputs. `pwr_oe` turns the driver on. `pwr_low_en` chooses low instead of high.

Top module: `pwake_ctrl`

## Requirements
- R1: While `rst_n` is low: `pwr_oe`, `pwr_low_en`, `wake_flag` and `kick_flag` are all 0. The pin is therefore high-impedance.
- R2: `alarm_hit` high at a clock edge with `wake_en` = 1 sets `wake_flag` and `pwr_low_en` (with `pwr_oe` = 1) at that edge. With `wake_en` = 0 the strobe has no effect.
- R3: `kick_n` is sampled at edges where `tick` is high. A kickstart event happens at the edge of the KICK_SAMPLES-th consecutive low sample (default 2). A low period yields at most one event. A high sample restarts the count. With `kick_en` = 1 the event sets `kick_flag` and `pwr_low_en`. With `kick_en` = 0 it is ignored.
- R4: The flag write `sw_wr` takes `sw_wdata` with bit 0 for the wake flag and bit 1 for the kick flag. A 0 in a bit clears that flag, and a 1 has no effect. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R5: `pwr_low_en` stays 1 while either flag is set and no timeout has expired. It returns to 0 at the edge that clears the last set flag.
- R6: While `pwr_low_en` = 1 and `pwr_fail` = 1, tick strobes are counted. At the TICK_HZ*TIMEOUT_SEC-th counted tick (default 16), `pwr_low_en` drops even though the flags stay set. Any tick with `pwr_fail` = 0 restarts the count. A new enabled event restarts the count and drives low again.
- R7: When not driving low, `pwr_oe` is 1 while `pwr_fail` = 0. While `pwr_fail` = 1 it equals `pf_keep`. The value follows the inputs at the previous edge.
- R8: Events arriving while `pwr_fail` = 1 still set their flags and drive the pin low with `pwr_oe` = 1, whatever `pf_keep` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow sample strobe, TICK_HZ per second |
| alarm_hit | input | 1 | Alarm-match strobe from the calendar |
| kick_n | input | 1 | Debounced kickstart input, active low |
| pwr_fail | input | 1 | 1 while main power is absent |
| wake_en | input | 1 | Enables alarm wake-up |
| kick_en | input | 1 | Enables kickstart wake-up |
| pf_keep | input | 1 | 1 keeps the pin driven through power fail |
| sw_wr | input | 1 | Flag write strobe |
| sw_wdata | input | 2 | Flag write data: bit 0 wake, bit 1 kick; 0 clears |
| pwr_low_en | output | 1 | Drive the power-enable pin low |
| pwr_oe | output | 1 | Power-enable driver on |
| wake_flag | output | 1 | Alarm wake-up recorded |
| kick_flag | output | 1 | Kickstart wake-up recorded |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `alarm_hit` and `tick` are single-cycle strobes and that `tick` never arrives on two adjacent cycles. The bench drives all inputs on the falling edge. Its tick strobe lasts one cycle in every four. It raises `alarm_hit` for exactly one cycle. It holds `kick_n` low for whole multiples of the tick period, so each low period spans a known number of samples.

// File: rtl/pwake_pkg.sv
package pwake_pkg;
  localparam int FLAG_W    = 2;
  localparam int FLAG_WAKE = 0;
  localparam int FLAG_KICK = 1;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/pwake_kick_filter.sv
module pwake_kick_filter #(
  parameter int KICK_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic kick_n_i,
  output logic hit_o
);
  localparam int RW = $clog2(KICK_SAMPLES + 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(KICK_SAMPLES);
  localparam logic [RW-1:0] RUN_LAST = RW'(KICK_SAMPLES - 1);

  logic [RW-1:0] run_q, run_d;
  logic          run_en;

  assign run_en = tick_i;

  always_comb begin
    run_d = run_q;
    if (kick_n_i)
      run_d = '0;
    else if (run_q != RUN_MAX)
      run_d = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (run_en)
      run_q <= run_d;
  end

  assign hit_o = tick_i && !kick_n_i && (run_q == RUN_LAST);

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/pwake_flag_bank.sv
module pwake_flag_bank
  import pwake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_i,
  input  logic      wr_i,
  input  flag_vec_t wdata_i,
  output flag_vec_t flags_o,
  output flag_vec_t flags_nxt_o
);
  flag_vec_t flags_q;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
    logic nxt;
    always_comb begin
      nxt = flags_q[b];
      if (wr_i && !wdata_i[b])
        nxt = 1'b0;
      if (set_i[b])
        nxt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags_q[b] <= 1'b0;
      else
        flags_q[b] <= nxt;
    end

    assign flags_nxt_o[b] = nxt;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> flags_o[b]);
    assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wdata_i[b] && !set_i[b]) |=> !flags_o[b]);
    assert_one_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[b] && !set_i[b] && !flags_o[b]) |=> !flags_o[b]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pwake_timeout.sv
module pwake_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  input  logic run_i,
  output logic expired_o,
  output logic expired_nxt_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          last_tick;

  assign last_tick = run_i && tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (arm_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (last_tick) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o     = exp_q;
  assign expired_nxt_o = exp_d;

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  assert_idle_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pwake_ctrl.sv
module pwake_ctrl
  import pwake_pkg::*;
#(
  parameter int TICK_HZ      = 8,
  parameter int TIMEOUT_SEC  = 2,
  parameter int KICK_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alarm_hit,
  input  logic       kick_n,
  input  logic       pwr_fail,
  input  logic       wake_en,
  input  logic       kick_en,
  input  logic       pf_keep,
  input  logic       sw_wr,
  input  logic [1:0] sw_wdata,
  output logic       pwr_low_en,
  output logic       pwr_oe,
  output logic       wake_flag,
  output logic       kick_flag
);
  localparam int TOUT_TICKS = TICK_HZ * TIMEOUT_SEC;

  logic      kick_hit;
  logic      any_evt;
  flag_vec_t evt_set;
  flag_vec_t flags_q, flags_nxt;
  logic      expired_q, expired_nxt;
  logic      low_q, low_d;
  logic      oe_q, oe_d;

  pwake_kick_filter #(.KICK_SAMPLES(KICK_SAMPLES)) u_kick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .kick_n_i (kick_n),
    .hit_o    (kick_hit)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[FLAG_WAKE] = alarm_hit && wake_en;
    evt_set[FLAG_KICK] = kick_hit && kick_en;
  end

  assign any_evt = |evt_set;

  pwake_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (evt_set),
    .wr_i        (sw_wr),
    .wdata_i     (sw_wdata),
    .flags_o     (flags_q),
    .flags_nxt_o (flags_nxt)
  );

  pwake_timeout #(.LIMIT(TOUT_TICKS)) u_tout (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick),
    .arm_i         (any_evt),
    .run_i         (low_q && pwr_fail),
    .expired_o     (expired_q),
    .expired_nxt_o (expired_nxt)
  );

  always_comb begin
    low_d = (|flags_nxt) && !expired_nxt;
    oe_d  = low_d || !pwr_fail || pf_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      low_q <= low_d;
      oe_q  <= oe_d;
    end
  end

  assign pwr_low_en = low_q;
  assign pwr_oe     = oe_q;
  assign wake_flag  = flags_q[FLAG_WAKE];
  assign kick_flag  = flags_q[FLAG_KICK];

  assert_alarm_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && wake_en) |=> (pwr_low_en && pwr_oe && wake_flag));
  assert_kick_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_hit && kick_en) |=> (pwr_low_en && pwr_oe && kick_flag));
  assert_float_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_oe && !pwr_low_en) |-> $past(!pwr_fail || pf_keep));
  assert_release_needs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_low_en) |-> (!wake_flag && !kick_flag) || expired_q);
  assert_no_flag_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_flag && !kick_flag) |-> !pwr_low_en);
endmodule

// File: tb/test_pwake_ctrl.sv
module test_pwake_ctrl;
  localparam int KS = 2;
  localparam int TL = 16;

  logic clk = 1'b0;
  logic rst_n, tick, alarm_hit, kick_n, pwr_fail, wake_en, kick_en, pf_keep, sw_wr;
  logic [1:0] sw_wdata;
  logic pwr_low_en, pwr_oe, wake_flag, kick_flag;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  bit tick_run = 0;
  int tick_div = 0;
  string cur_req = "R1";

  int m_run, m_cnt;
  bit m_wake, m_kick, m_tout, m_low, m_oe;

  always #4 clk = ~clk;

  pwake_ctrl #(.TICK_HZ(8), .TIMEOUT_SEC(2), .KICK_SAMPLES(KS)) i_pwake_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_hit(alarm_hit), .kick_n(kick_n),
    .pwr_fail(pwr_fail), .wake_en(wake_en), .kick_en(kick_en), .pf_keep(pf_keep),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .pwr_low_en(pwr_low_en), .pwr_oe(pwr_oe),
    .wake_flag(wake_flag), .kick_flag(kick_flag)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_wake = 0; m_kick = 0; m_tout = 0; m_low = 0; m_oe = 0;
    end else begin
      bit kev, aev, drv_before;
      kev = 0;
      aev = alarm_hit && wake_en;
      drv_before = m_low;
      if (tick) begin
        if (kick_n) m_run = 0;
        else begin
          if (m_run == KS - 1) kev = kick_en;
          if (m_run < KS) m_run++;
        end
      end
      if (aev || kev) begin m_cnt = 0; m_tout = 0; end
      else if (!drv_before || !pwr_fail) m_cnt = 0;
      else if (tick) begin
        m_cnt++;
        if (m_cnt == TL) begin m_tout = 1; m_cnt = 0; end
      end
      if (sw_wr && !sw_wdata[0]) m_wake = 0;
      if (sw_wr && !sw_wdata[1]) m_kick = 0;
      if (aev) m_wake = 1;
      if (kev) m_kick = 1;
      m_low = (m_wake || m_kick) && !m_tout;
      m_oe  = m_low || !pwr_fail || pf_keep;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      chk(cur_req, "pwr_low_en", pwr_low_en, m_low);
      chk(cur_req, "pwr_oe", pwr_oe, m_oe);
      chk(cur_req, "wake_flag", wake_flag, m_wake);
      chk(cur_req, "kick_flag", kick_flag, m_kick);
    end
    if (tick_run) begin
      tick <= (tick_div == 3);
      tick_div = (tick_div + 1) % 4;
    end else tick <= 1'b0;
  end

  always @(negedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alarm_pulse();
    @(negedge clk); alarm_hit = 1;
    @(negedge clk); alarm_hit = 0;
  endtask

  task automatic sw_write(logic [1:0] d);
    @(negedge clk); sw_wr = 1; sw_wdata = d;
    @(negedge clk); sw_wr = 0; sw_wdata = 2'b11;
  endtask

  initial begin
    rst_n = 0; tick = 0; alarm_hit = 0; kick_n = 1; pwr_fail = 0;
    wake_en = 0; kick_en = 0; pf_keep = 0; sw_wr = 0; sw_wdata = 2'b11;
    step(3);
    cur_req = "R1";
    chk("R1", "pwr_oe in reset", pwr_oe, 1'b0);
    chk("R1", "pwr_low_en in reset", pwr_low_en, 1'b0);
    chk("R1", "flags in reset", wake_flag | kick_flag, 1'b0);
    rst_n = 1;
    tick_run = 1;
    step(2);

    cur_req = "R7";
    chk("R7", "oe with power", pwr_oe, 1'b1);
    pwr_fail = 1; step(2);
    chk("R7", "oe float on fail", pwr_oe, 1'b0);
    pf_keep = 1; step(2);
    chk("R7", "oe kept on fail", pwr_oe, 1'b1);
    pwr_fail = 0; pf_keep = 0; step(2);

    cur_req = "R2";
    alarm_pulse(); step(1);
    chk("R2", "alarm ignored when disabled", wake_flag, 1'b0);
    wake_en = 1; alarm_pulse();
    chk("R2", "wake flag set", wake_flag, 1'b1);
    chk("R2", "drive low on alarm", pwr_low_en, 1'b1);

    cur_req = "R4";
    sw_write(2'b11); step(1);
    chk("R4", "write one no effect", wake_flag, 1'b1);
    cur_req = "R5";
    step(40);
    chk("R5", "held while flag set", pwr_low_en, 1'b1);
    sw_write(2'b10);
    chk("R5", "release after clear", pwr_low_en, 1'b0);
    chk("R4", "wake cleared by zero", wake_flag, 1'b0);

    cur_req = "R3";
    kick_en = 1;
    @(negedge clk); kick_n = 0; step(4); kick_n = 1; step(6);
    chk("R3", "single low sample ignored", kick_flag, 1'b0);
    kick_n = 0; step(12); kick_n = 1; step(1);
    chk("R3", "kick flag after two samples", kick_flag, 1'b1);
    chk("R3", "kick drives low", pwr_low_en, 1'b1);
    sw_write(2'b01); step(1);
    chk("R3", "kick cleared", kick_flag, 1'b0);
    kick_en = 0; kick_n = 0; step(16); kick_n = 1; step(2);
    chk("R3", "kick ignored when disabled", kick_flag, 1'b0);

    cur_req = "R4";
    @(negedge clk); alarm_hit = 1; sw_wr = 1; sw_wdata = 2'b00;
    @(negedge clk); alarm_hit = 0; sw_wr = 0; sw_wdata = 2'b11;
    chk("R4", "event beats clear", wake_flag, 1'b1);

    cur_req = "R6";
    step(130);
    chk("R6", "no timeout with main power", pwr_low_en, 1'b1);
    pwr_fail = 1; step(40);
    chk("R6", "still driving before timeout", pwr_low_en, 1'b1);
    step(80);
    chk("R6", "released by timeout", pwr_low_en, 1'b0);
    chk("R6", "flag kept after timeout", wake_flag, 1'b1);
    chk("R7", "float after timeout", pwr_oe, 1'b0);
    alarm_pulse();
    chk("R6", "re-armed by new event", pwr_low_en, 1'b1);
    sw_write(2'b00); step(1);

    cur_req = "R8";
    chk("R8", "floating before kick", pwr_oe, 1'b0);
    kick_en = 1; kick_n = 0; step(12); kick_n = 1; step(1);
    chk("R8", "kick during power fail", pwr_low_en, 1'b1);
    chk("R8", "driver on during power fail", pwr_oe, 1'b1);
    sw_write(2'b00); step(2);
    pwr_fail = 0; step(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule